// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Controller

This block decides which maskable interrupt a small processor core takes next, and when. Each of `N_SRC` level-sensitive request lines has a mask bit and a one-bit level: level 0 is high and level 1 is low. A global enable flag (`ie`) and an in-service-level flag (`isp`) decide whether a request may interrupt the code that is running. The core presents an instruction-boundary strobe and decoded commands: enable interrupts, disable interrupts, return from interrupt, and a software break. The block answers with a single-cycle acknowledge pulse and the index of the winning vector.

Each acknowledge clears `ie`. A service routine that wants to be interrupted by another request must therefore set `ie` again itself. A high-level request may interrupt any routine. A low-level request may interrupt only when no high-level routine is running. Before each acknowledge, the current flag pair is pushed onto a small stack. A return pops the pair and restores it. The first boundary after a return never takes an interrupt, so at least one main-line instruction runs before a pending request is taken.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `ie`=0, `isp`=1, `ack`=0, `stk_err`=0 and `ack_vec`=0.
- R2: The block acknowledges only on a cycle where `boundary`=1 and none of `cmd_ei`, `cmd_di` or `cmd_reti` is high. `ack` is high for exactly the one cycle after that boundary edge, and `ack_vec` is valid in that cycle.
- R3: Every acknowledge clears `ie`. `cmd_ei` sets `ie` and `cmd_di` clears it.
- R4: No maskable request is acknowledged while `ie`=0. A request held through this time is acknowledged at a later boundary once `ie`=1.
- R5: A high-level request (level bit 0) is acknowledged whenever `ie`=1, whatever the value of `isp`, and its acknowledge sets `isp` to 0.
- R6: A low-level request (level bit 1) needs both `ie`=1 and `isp`=1. Its acknowledge leaves `isp` unchanged.
- R7: Any eligible high-level request beats every low-level request. Within one level, the lowest source index wins, and `ack_vec` carries that index.
- R8: A source whose mask bit is 1 never takes part in arbitration.
- R9: `cmd_reti` pops the most recently pushed {`ie`,`isp`} pair and restores both flags. A return on an empty stack leaves both flags unchanged.
- R10: The first boundary after `cmd_reti` produces no acknowledge, whatever is pending.
- R11: `sw_brk` high at an eligible boundary is acknowledged even when `ie`=0 and beats every maskable request. Its `ack_vec` is `N_SRC`. It clears `ie`, leaves `isp` unchanged, and pushes the flags.
- R12: An acknowledge that arrives with `DEPTH` entries already stacked sets `stk_err`. `stk_err` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC | Level-sensitive request lines |
| irq_mask | input | N_SRC | 1 = source masked |
| irq_lvl | input | N_SRC | 0 = high level, 1 = low level |
| boundary | input | 1 | Instruction-boundary strobe |
| cmd_ei | input | 1 | Enable-interrupts command |
| cmd_di | input | 1 | Disable-interrupts command |
| cmd_reti | input | 1 | Return-from-interrupt command |
| sw_brk | input | 1 | Software-break request |
| ack | output | 1 | Acknowledge pulse |
| ack_vec | output | $clog2(N_SRC+1) | Winning vector index (N_SRC = break) |
| ie | output | 1 | Global interrupt enable flag |
| isp | output | 1 | In-service level flag (0 = high-level routine running) |
| stk_err | output | 1 | Sticky flag-stack overflow |

## Verification
The assertions assume that a request line stays asserted until it is acknowledged. They also assume that commands and the boundary strobe are single-cycle pulses, sampled on the clock edge. Some properties compare the request vector at a boundary with the acknowledge one cycle later, so they take the request, mask and level inputs as stable across that edge. The stimulus changes inputs only at the falling edge and keeps requests up until they are taken. Apart from one deliberate collision case, it never raises a command in a boundary cycle.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
   typedef struct packed {
      logic ie;
      logic isp;
   } irq_flags_t;

   localparam irq_flags_t FLAGS_IDLE = '{ie: 1'b0, isp: 1'b1};
endpackage

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
   parameter int W  = 8,
   parameter int IW = 4
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   generate
      if (W == 1) begin : g_single
         assign found = vec[0];
         assign idx   = '0;
      end else begin : g_scan
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (vec[i]) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_flag_stack.sv
module irq_flag_stack
   import nest_irq_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  logic       pop,
   input  irq_flags_t din,
   output irq_flags_t dout,
   output logic       empty,
   output logic       full
);
   localparam int SPW = $clog2(DEPTH + 1);

   logic [SPW-1:0]        sp;
   logic [DEPTH-1:0][1:0] slots;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         irq_flags_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q <= FLAGS_IDLE;
            else if (push && sp == SPW'(g))    q <= din;
         end
         assign slots[g] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              sp <= '0;
      else if (push && !full)  sp <= sp + SPW'(1);
      else if (pop && !empty)  sp <= sp - SPW'(1);
   end

   assign empty = (sp == '0);
   assign full  = (sp == SPW'(DEPTH));

   always_comb begin
      dout = FLAGS_IDLE;
      for (int i = 0; i < DEPTH; i++) begin
         if (sp == SPW'(i + 1)) dout = irq_flags_t'(slots[i]);
      end
   end
endmodule

// File: rtl/irq_nest_seq.sv
module irq_nest_seq
   import nest_irq_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int VW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          boundary,
   input  logic          cmd_ei,
   input  logic          cmd_di,
   input  logic          cmd_reti,
   input  logic          sw_brk,
   input  logic          hi_found,
   input  logic [VW-1:0] hi_idx,
   input  logic          lo_found,
   input  logic [VW-1:0] lo_idx,
   input  irq_flags_t    stk_top,
   input  logic          stk_empty,
   input  logic          stk_full,
   output logic          stk_push,
   output logic          stk_pop,
   output irq_flags_t    cur_flags,
   output logic          ack,
   output logic [VW-1:0] ack_vec,
   output logic          stk_err
);
   logic cmd_any, ret_hold, take;
   logic brk_go, hi_go, lo_go, any_go;
   irq_flags_t flags_q;

   assign cmd_any = cmd_ei | cmd_di | cmd_reti;
   assign take    = boundary & ~cmd_any & ~ret_hold;
   assign brk_go  = take & sw_brk;
   assign hi_go   = take & ~sw_brk & flags_q.ie & hi_found;
   assign lo_go   = take & ~sw_brk & flags_q.ie & flags_q.isp & ~hi_found & lo_found;
   assign any_go  = brk_go | hi_go | lo_go;

   assign stk_push  = any_go & ~stk_full;
   assign stk_pop   = cmd_reti & ~stk_empty;
   assign cur_flags = flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= FLAGS_IDLE;
      end else if (any_go) begin
         flags_q.ie <= 1'b0;
         if (hi_go) flags_q.isp <= 1'b0;
      end else if (stk_pop) begin
         flags_q <= stk_top;
      end else if (cmd_ei) begin
         flags_q.ie <= 1'b1;
      end else if (cmd_di) begin
         flags_q.ie <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ret_hold <= 1'b0;
      else if (cmd_reti)  ret_hold <= 1'b1;
      else if (boundary)  ret_hold <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack     <= 1'b0;
         ack_vec <= '0;
         stk_err <= 1'b0;
      end else begin
         ack <= any_go;
         if (brk_go)      ack_vec <= VW'(N_SRC);
         else if (hi_go)  ack_vec <= hi_idx;
         else if (lo_go)  ack_vec <= lo_idx;
         else             ack_vec <= '0;
         if (any_go && stk_full) stk_err <= 1'b1;
      end
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nest_irq_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int DEPTH = 4,
   localparam int VW   = $clog2(N_SRC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_req,
   input  logic [N_SRC-1:0] irq_mask,
   input  logic [N_SRC-1:0] irq_lvl,
   input  logic             boundary,
   input  logic             cmd_ei,
   input  logic             cmd_di,
   input  logic             cmd_reti,
   input  logic             sw_brk,
   output logic             ack,
   output logic [VW-1:0]    ack_vec,
   output logic             ie,
   output logic             isp,
   output logic             stk_err
);
   generate
      if (N_SRC < 1 || N_SRC > 64) begin : g_bad_nsrc
         $error("nest_irq_ctrl: N_SRC must be 1..64");
      end
      if (DEPTH < 1 || DEPTH > 32) begin : g_bad_depth
         $error("nest_irq_ctrl: DEPTH must be 1..32");
      end
   endgenerate

   logic [N_SRC-1:0] live, hi_vec, lo_vec;
   logic             hi_found, lo_found;
   logic [VW-1:0]    hi_idx, lo_idx;
   logic             push, pop, s_empty, s_full;
   irq_flags_t       top_flags, flags;

   assign live   = irq_req & ~irq_mask;
   assign hi_vec = live & ~irq_lvl;
   assign lo_vec = live &  irq_lvl;

   irq_prio_find #(.W(N_SRC), .IW(VW)) hi_find_i (
      .vec(hi_vec), .found(hi_found), .idx(hi_idx));
   irq_prio_find #(.W(N_SRC), .IW(VW)) lo_find_i (
      .vec(lo_vec), .found(lo_found), .idx(lo_idx));

   irq_flag_stack #(.DEPTH(DEPTH)) stack_i (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .din(flags), .dout(top_flags), .empty(s_empty), .full(s_full));

   irq_nest_seq #(.N_SRC(N_SRC), .VW(VW)) seq_i (
      .clk(clk), .rst_n(rst_n), .boundary(boundary),
      .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_reti(cmd_reti), .sw_brk(sw_brk),
      .hi_found(hi_found), .hi_idx(hi_idx), .lo_found(lo_found), .lo_idx(lo_idx),
      .stk_top(top_flags), .stk_empty(s_empty), .stk_full(s_full),
      .stk_push(push), .stk_pop(pop), .cur_flags(flags),
      .ack(ack), .ack_vec(ack_vec), .stk_err(stk_err));

   assign ie  = flags.ie;
   assign isp = flags.isp;
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
   parameter int N_SRC = 8,
   localparam int VW   = $clog2(N_SRC + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] irq_req,
   input logic [N_SRC-1:0] irq_mask,
   input logic [N_SRC-1:0] irq_lvl,
   input logic             boundary,
   input logic             cmd_ei,
   input logic             cmd_di,
   input logic             cmd_reti,
   input logic             sw_brk,
   input logic             ack,
   input logic [VW-1:0]    ack_vec,
   input logic             ie,
   input logic             isp,
   input logic             stk_err
);
   logic any_hi;
   assign any_hi = |(irq_req & ~irq_mask & ~irq_lvl);

   // R2
   ack_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> !ack);
   // R2
   ack_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ack_vec <= VW'(N_SRC));
   // R3
   ack_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !ie);
   // R4
   no_ack_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !ie && !sw_brk) |=> !ack);
   // R6
   low_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !isp && !any_hi && !sw_brk) |=> !ack);
   // R10
   hold_after_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && $past(cmd_reti)) |=> !ack);
   // R11
   brk_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_vec == VW'(N_SRC)) |-> $past(sw_brk));
   // R12
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_err |=> stk_err);
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.N_SRC(N_SRC)) chk_i (.*);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
   localparam int N  = 8;
   localparam int D  = 4;
   localparam int VW = $clog2(N + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] irq_req, irq_mask, irq_lvl;
   logic boundary, cmd_ei, cmd_di, cmd_reti, sw_brk;
   logic ack, ie, isp, stk_err;
   logic [VW-1:0] ack_vec;
   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   nest_irq_ctrl #(.N_SRC(N), .DEPTH(D)) dut_i (.*);

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic bnd();
      boundary = 1'b1; tick(); boundary = 1'b0;
   endtask

   task automatic ei();   cmd_ei = 1'b1;   tick(); cmd_ei = 1'b0;   endtask
   task automatic reti(); cmd_reti = 1'b1; tick(); cmd_reti = 1'b0; endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_req = '0; irq_mask = '0; irq_lvl = '0;
      boundary = 0; cmd_ei = 0; cmd_di = 0; cmd_reti = 0; sw_brk = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; tick();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 ie", ie, 0); chk("R1 isp", isp, 1);
      chk("R1 ack", ack, 0); chk("R1 err", stk_err, 0); chk("R1 vec", ack_vec, 0);
   endtask

   task automatic t_pending();
      do_reset();
      irq_req[2] = 1'b1;
      bnd(); chk("R4 no ack ie=0", ack, 0);
      ei(); chk("R3 ei sets", ie, 1);
      bnd(); chk("R4 later ack", ack, 1); chk("R4 vec", ack_vec, 2);
      chk("R3 ack clears ie", ie, 0); chk("R5 isp hi", isp, 0);
      irq_req = '0;
      tick(); chk("R2 single pulse", ack, 0);
      cmd_di = 1'b1; tick(); cmd_di = 1'b0;
      chk("R3 di clears", ie, 0);
   endtask

   task automatic t_collide();
      do_reset();
      ei(); irq_req[1] = 1'b1;
      boundary = 1'b1; cmd_ei = 1'b1; tick(); boundary = 1'b0; cmd_ei = 1'b0;
      chk("R2 cmd blocks ack", ack, 0);
      bnd(); chk("R2 ack after", ack, 1); chk("R2 vec", ack_vec, 1);
   endtask

   task automatic t_nest();
      do_reset();
      ei();
      irq_lvl = 8'b0000_1010;
      irq_req = 8'b0110_1010;
      bnd(); chk("R7 hi beats lo", ack_vec, 5); chk("R5 isp0", isp, 0);
      ei(); irq_req[5] = 1'b0;
      bnd(); chk("R5 nested hi", ack, 1); chk("R7 vec6", ack_vec, 6);
      irq_req[6] = 1'b0; ei();
      bnd(); chk("R6 lo blocked isp0", ack, 0);
      reti(); chk("R9 pop ie", ie, 1); chk("R9 pop isp", isp, 0);
      bnd(); chk("R10 hold", ack, 0);
      bnd(); chk("R6 still blocked", ack, 0);
      reti(); chk("R9 pop2 isp", isp, 1); chk("R9 pop2 ie", ie, 1);
      bnd(); chk("R10 hold2", ack, 0);
      bnd(); chk("R6 lo ack", ack, 1); chk("R7 lowest lo", ack_vec, 1);
      chk("R6 isp kept", isp, 1); chk("R3 ie0", ie, 0);
      reti(); reti(); chk("R9 empty keeps isp", isp, 1); chk("R9 empty keeps ie", ie, 1);
   endtask

   task automatic t_mask();
      do_reset();
      ei();
      irq_lvl = 8'b0001_0000;
      irq_mask[0] = 1'b1; irq_req = 8'b0001_0001;
      bnd(); chk("R8 masked skipped", ack_vec, 4);
      irq_req = 8'b0000_0001; ei();
      bnd(); chk("R8 masked only", ack, 0);
   endtask

   task automatic t_brk();
      do_reset();
      irq_req[0] = 1'b1; sw_brk = 1'b1;
      bnd(); chk("R11 brk ie0", ack, 1); chk("R11 vec", ack_vec, N);
      chk("R11 isp", isp, 1); chk("R11 ie", ie, 0);
      sw_brk = 1'b0; ei(); sw_brk = 1'b1;
      bnd(); chk("R11 beats hi", ack_vec, N);
      sw_brk = 1'b0;
   endtask

   task automatic t_overflow();
      do_reset();
      sw_brk = 1'b1;
      for (int i = 0; i < D; i++) bnd();
      chk("R12 no err at depth", stk_err, 0);
      bnd(); chk("R12 err", stk_err, 1);
      sw_brk = 1'b0;
      reti(); tick(); chk("R12 sticky", stk_err, 1);
   endtask

   initial begin
      t_reset(); t_pending(); t_collide(); t_nest();
      t_mask(); t_brk(); t_overflow();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule